// File: doc/BRIEF.md
# Mixed-Polarity Toffoli Cascade Evaluator

This block evaluates a programmed cascade of reversible gates on a state vector of up to eight lines. Software or a controlling engine first writes gate entries into a small gate store. Each entry holds a target line index, a control mask and a polarity mask. A start strobe then loads an input vector. The block applies one gate per clock cycle and pulses `done` when the final vector is on `vec_out`.

A gate flips its target line only when each of its control lines matches the requested polarity. A polarity bit of 1 means the line must be 1. A polarity bit of 0 means the line must be 0. A gate with no controls is an inverter. With one control it is a controlled inverter, and with two it is a Toffoli gate.

Every such gate is its own inverse. Running the same list from the last entry back to the first therefore computes the inverse permutation. The `reverse` input selects that order when start is accepted. An entry whose control mask covers its own target line is illegal. It is applied as a no-op and recorded on the `illegal` flag.

Top module: `toffoli_cascade`

## Requirements
- R1: After reset, `busy`, `done`, `illegal` and `vec_out` are all 0.
- R2: A cycle with `wr_en` high stores `wr_tgt`, `wr_ctl` and `wr_pol` into gate entry `wr_addr`. Later runs use that entry.
- R3: A gate inverts its target line only if every line with its `ctl` bit set equals that line's `pol` bit (1 = positive control, 0 = negative control). Lines whose `ctl` bit is 0 have no effect. No line other than the target ever changes.
- R4: With 0, 1 and 2 controls, a gate behaves as NOT, controlled-NOT and Toffoli on its target.
- R5: With `reverse` low at start, entries 0 to N-1 are applied in ascending order, where N is `gate_count` clamped to the store depth.
- R6: With `reverse` high at start, entries N-1 down to 0 are applied. A reverse run fed the result of a forward run returns the original input.
- R7: An entry whose control mask includes its target bit, or whose target index is at least LINES, leaves the state unchanged. `illegal` then reads 1 from that gate until the next accepted start, and it reads 0 after a run with only legal entries.
- R8: `start` is accepted only when `busy` is low. `done` pulses high for one cycle, max(N,1) rising edges after the accepting edge. `busy` is high in between.
- R9: `start` asserted while `busy` is high is ignored. The running result and the `done` timing are unaffected.
- R10: `vec_out` holds the final vector from the `done` cycle until the next accepted start. With N = 0 it equals the input vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Gate entry write strobe |
| wr_addr | input | AW | Entry index to write |
| wr_tgt | input | TW | Target line of the written entry |
| wr_ctl | input | LINES | Control mask of the written entry |
| wr_pol | input | LINES | Polarity mask (1 positive, 0 negative) |
| start | input | 1 | Load vector and begin a run |
| reverse | input | 1 | Apply entries last-to-first for this run |
| gate_count | input | CW | Number of entries in the cascade |
| vec_in | input | LINES | Input state vector |
| vec_out | output | LINES | Current / result state vector |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| illegal | output | 1 | An illegal entry was hit in this run |

## Verification
The bench mixes positive and negative controls on shared lines. A design that inverted the polarity sense, or that let uncontrolled lines gate the flip, gives the wrong result vectors. Forward-then-reverse round trips use gates that do not commute, so a pointer that walks the wrong way or starts one entry off fails the round trip. Self-targeting entries, a zero-length cascade, a full-depth cascade and a start pulse in mid-run probe the off-by-one counter, the illegal flag and the start gating. A faulty design would show wrong latency, a lost or corrupted result, or a flag that stays stuck.

// File: rtl/toffoli_cascade.sv
module toffoli_cascade #(
  parameter int LINES = 8,
  parameter int DEPTH = 16,
  localparam int TW = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [TW-1:0]    wr_tgt,
  input  logic [LINES-1:0] wr_ctl,
  input  logic [LINES-1:0] wr_pol,
  input  logic             start,
  input  logic             reverse,
  input  logic [CW-1:0]    gate_count,
  input  logic [LINES-1:0] vec_in,
  output logic [LINES-1:0] vec_out,
  output logic             busy,
  output logic             done,
  output logic             illegal
);

  logic [TW-1:0]    mem_tgt [DEPTH];
  logic [LINES-1:0] mem_ctl [DEPTH];
  logic [LINES-1:0] mem_pol [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_tgt[wr_addr] <= wr_tgt;
      mem_ctl[wr_addr] <= wr_ctl;
      mem_pol[wr_addr] <= wr_pol;
    end
  end

  logic [LINES-1:0] state;
  logic [AW-1:0]    ptr;
  logic [CW-1:0]    rem;
  logic             rev_q;

  wire [CW-1:0]    n_eff    = (gate_count > CW'(DEPTH)) ? CW'(DEPTH) : gate_count;
  wire [TW-1:0]    cur_tgt  = mem_tgt[ptr];
  wire [LINES-1:0] cur_ctl  = mem_ctl[ptr];
  wire [LINES-1:0] cur_pol  = mem_pol[ptr];
  wire [LINES-1:0] tgt_mask = LINES'(1) << cur_tgt;
  wire             bad      = (tgt_mask == '0) || ((tgt_mask & cur_ctl) != '0);
  wire             fire     = ((state ~^ cur_pol) & cur_ctl) == cur_ctl;
  wire [LINES-1:0] nxt      = (fire && !bad) ? (state ^ tgt_mask) : state;
  wire             accept   = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= '0;
      ptr     <= '0;
      rem     <= '0;
      rev_q   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state   <= vec_in;
        rem     <= n_eff;
        rev_q   <= reverse;
        ptr     <= (reverse && n_eff != '0) ? AW'(n_eff - 1'b1) : '0;
        busy    <= 1'b1;
        illegal <= 1'b0;
      end else if (busy) begin
        if (rem == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          state <= nxt;
          if (bad) illegal <= 1'b1;
          rem <= rem - 1'b1;
          ptr <= rev_q ? ptr - 1'b1 : ptr + 1'b1;
          if (rem == CW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assign vec_out = state;

  p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> $countones(state ^ $past(state)) <= 1);

  p_ctl_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem != '0) |=> ((state ^ $past(state)) & $past(cur_ctl)) == '0);

  p_illegal_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem != '0 && bad) |=> ($stable(state) && illegal));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(vec_out));

endmodule

// File: tb/sim_toffoli_cascade.sv
module sim_toffoli_cascade;
  localparam int LINES = 8;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [2:0] wr_tgt = 0;
  logic [7:0] wr_ctl = 0, wr_pol = 0;
  logic start = 0, reverse = 0;
  logic [4:0] gate_count = 0;
  logic [7:0] vec_in = 0;
  logic [7:0] vec_out;
  logic busy, done, illegal;

  int checks = 0, fails = 0;
  int mt [DEPTH];
  logic [7:0] mc [DEPTH];
  logic [7:0] mp [DEPTH];

  always #2.5 clk = ~clk;

  toffoli_cascade #(.LINES(LINES), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_tgt(wr_tgt),
    .wr_ctl(wr_ctl), .wr_pol(wr_pol), .start(start), .reverse(reverse),
    .gate_count(gate_count), .vec_in(vec_in), .vec_out(vec_out), .busy(busy),
    .done(done), .illegal(illegal));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input int t, input logic [7:0] c, input logic [7:0] p);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = 4'(a); wr_tgt = 3'(t); wr_ctl = c; wr_pol = p;
    mt[a] = t; mc[a] = c; mp[a] = p;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  function automatic logic [7:0] model(input logic [7:0] v, input bit rev, input int n);
    logic [7:0] s = v;
    for (int k = 0; k < n; k++) begin
      int i = rev ? n - 1 - k : k;
      bit ok = 1;
      if (mc[i][mt[i]]) continue;
      for (int b = 0; b < 8; b++)
        if (mc[i][b] && s[b] != mp[i][b]) ok = 0;
      if (ok) s[mt[i]] = ~s[mt[i]];
    end
    return s;
  endfunction

  task automatic run(input logic [7:0] v, input bit rev, input int n,
                     input bit poke, output logic [7:0] res);
    int edges = 0;
    int exp_lat = (n > 0) ? n : 1;
    @(posedge clk); #1;
    start = 1; reverse = rev; gate_count = 5'(n); vec_in = v;
    @(posedge clk); #1;
    start = 0; reverse = 0; vec_in = 8'h00;
    chk("R8 busy after start", busy, 1);
    while (!done && edges < 100) begin
      if (poke && edges == 1) begin start = 1; vec_in = ~v; gate_count = 0; end
      @(posedge clk); #1;
      start = 0;
      edges++;
    end
    chk("R8 latency", edges, exp_lat);
    chk("R8 busy low at done", busy, 0);
    res = vec_out;
    @(posedge clk); #1;
    chk("R8 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 illegal", illegal, 0);
    chk("R1 vec_out", vec_out, 0);
  endtask

  task automatic t_basic();
    logic [7:0] r;
    logic [7:0] vs [4] = '{8'h00, 8'h1A, 8'hFF, 8'h18};
    put(0, 0, 8'h00, 8'h00);
    put(1, 2, 8'h02, 8'h02);
    put(2, 5, 8'h18, 8'h18);
    foreach (vs[i]) begin
      run(vs[i], 0, 3, 0, r);
      chk("R4 R2 NOT/CNOT/Toffoli", r, model(vs[i], 0, 3));
    end
    run(8'h18, 0, 3, 0, r);
    chk("R4 Toffoli fires", r, 8'h39);
  endtask

  task automatic t_negative();
    logic [7:0] r;
    put(0, 7, 8'h03, 8'h01);
    run(8'h01, 0, 1, 0, r); chk("R3 neg ctl fires", r, 8'h81);
    run(8'h03, 0, 1, 0, r); chk("R3 neg ctl blocks", r, 8'h03);
    run(8'h00, 0, 1, 0, r); chk("R3 pos ctl blocks", r, 8'h00);
    run(8'hFD, 0, 1, 0, r); chk("R3 other lines ignored", r, 8'h7D);
  endtask

  task automatic t_inverse();
    logic [7:0] f, b;
    logic [7:0] xs [3] = '{8'h5A, 8'h00, 8'hC3};
    put(0, 1, 8'h01, 8'h01);
    put(1, 0, 8'h06, 8'h04);
    put(2, 2, 8'h03, 8'h00);
    put(3, 6, 8'h00, 8'h00);
    put(4, 1, 8'h44, 8'h40);
    put(5, 4, 8'h82, 8'h02);
    foreach (xs[i]) begin
      run(xs[i], 0, 6, 0, f);
      chk("R5 forward order", f, model(xs[i], 0, 6));
      run(f, 1, 6, 0, b);
      chk("R6 round trip", b, xs[i]);
      run(xs[i], 1, 6, 0, b);
      chk("R6 reverse order", b, model(xs[i], 1, 6));
    end
  endtask

  task automatic t_illegal();
    logic [7:0] r;
    put(0, 3, 8'h08, 8'h08);
    run(8'h08, 0, 1, 0, r);
    chk("R7 illegal no change", r, 8'h08);
    chk("R7 illegal flag", illegal, 1);
    put(0, 3, 8'h00, 8'h00);
    run(8'h08, 0, 1, 0, r);
    chk("R7 legal result", r, 8'h00);
    chk("R7 flag cleared", illegal, 0);
  endtask

  task automatic t_busy_start();
    logic [7:0] r;
    for (int i = 0; i < 5; i++) put(i, i, 8'h00, 8'h00);
    run(8'hA0, 0, 5, 1, r);
    chk("R9 start ignored when busy", r, 8'hBF);
  endtask

  task automatic t_zero_full();
    logic [7:0] r;
    run(8'h6E, 0, 0, 0, r);
    chk("R10 zero count passthrough", r, 8'h6E);
    for (int i = 0; i < DEPTH; i++) put(i, i % 8, 8'h00, 8'h00);
    run(8'h0F, 0, DEPTH, 0, r);
    chk("R5 full depth", r, 8'h0F);
    run(8'h11, 0, 9, 0, r);
    chk("R5 partial", r, 8'hEF);
    repeat (3) @(posedge clk);
    #1 chk("R10 result held", vec_out, 8'hEF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1;
    t_basic();
    t_negative();
    t_inverse();
    t_illegal();
    t_busy_start();
    t_zero_full();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule